// File: doc/BRIEF.md
# User Interrupt Pending and Enable Logic

This block holds the pending and enable state of the three user-level interrupt sources (software, timer, external). It exposes that state through two pairs of register views. The user pending and user enable views are narrow windows onto the same storage that the machine pending and machine enable views show. Any access through a user view reaches the machine-level bit directly; there is no second copy.

From these bits the block raises an interrupt-take request and a cause code. A source competes only when it is pending, enabled, delegated to user level, the global user interrupt enable is set, and the hart is running in user mode. When several sources are ready, a fixed priority picks one. The timer and external platform lines are level inputs that are ORed into the pending bits. Trap entry register updates happen outside this block.

Top module: `uirq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every stored pending and enable bit is zero. All four views read zero and `irq_req_o` is 0.
- R2: The software pending bit (bit 0) is written from `csr_wdata_i[0]` by any permitted write to a pending view. The four view codes are user pending = 0, user enable = 1, machine pending = 2 and machine enable = 3. The bit reads back identically through both pending views.
- R3: A user-mode write (`priv_user_i`=1) to the user pending view changes only bit 0. In machine mode, bits 4 (timer) and 8 (external) of a pending-view write load held copies. Pending bits 4 and 8 read as the held copy ORed with `tmr_line_i` and `ext_line_i` respectively.
- R4: Enable bits 0, 4 and 8 are written through either enable view from either mode, subject to R5. Both enable views read the same three bits.
- R5: In user mode, a write to a machine view (codes 2 and 3) changes nothing, and a read of a machine view returns zero.
- R6: Every bit position other than 0, 4 and 8 reads zero in every view and ignores writes.
- R7: `irq_req_o` is 1 only when some source has its pending, enable and `deleg_i` bits set, with `uie_i`=1 and `priv_user_i`=1. Clearing any one of these removes the request in the same cycle.
- R8: Among ready sources, external (code 8) wins over software (code 0), and software wins over timer (code 4). `irq_code_o` carries the winner's bit position.
- R9: While `irq_req_o` is 0, `irq_code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_line_i | input | 1 | Platform timer pending level |
| ext_line_i | input | 1 | Platform external pending level |
| csr_sel_i | input | 2 | View select: 0 user pending, 1 user enable, 2 machine pending, 3 machine enable |
| csr_we_i | input | 1 | Write strobe for the selected view |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data of the selected view (combinational) |
| priv_user_i | input | 1 | 1 when the hart runs in user mode |
| uie_i | input | 1 | Global user interrupt enable |
| deleg_i | input | XLEN | Interrupt delegation mask, same bit positions as pending |
| irq_req_o | output | 1 | Interrupt-take request |
| irq_code_o | output | CAUSE_W | Cause code of the winning source |

## Verification
The bench builds the block with XLEN = 32 and CAUSE_W = 4. These are the widths that cover every implemented field and the largest cause value, 8. With a full 32-bit word, writes of all ones reach every unimplemented position, so R6 is observable across the whole register. It also makes the delegation mask's unused upper bits part of the stimulus. Priority is exercised by switching the sources on and off one at a time while all three are ready. Each gating term of R7 is removed alone.

// File: rtl/uirq_pkg.sv
// Package: shared constants for the user interrupt logic.
// Assumes three sources at fixed bit positions; source indices are
// 0 = software, 1 = timer, 2 = external.
package uirq_pkg;

    localparam int NSRC = 3;

    typedef enum logic [1:0] {
        VIEW_UPEND = 2'd0,
        VIEW_UEN   = 2'd1,
        VIEW_MPEND = 2'd2,
        VIEW_MEN   = 2'd3
    } view_e;

    localparam int SRC_SW  = 0;
    localparam int SRC_TMR = 1;
    localparam int SRC_EXT = 2;

    // Bit position (and cause code) of a source index.
    function automatic int src_pos(input int idx);
        return idx * 4;
    endfunction

    // Source index holding priority rank k (0 = highest).
    function automatic int prio_src(input int k);
        case (k)
            0:       return SRC_EXT;
            1:       return SRC_SW;
            default: return SRC_TMR;
        endcase
    endfunction

endpackage

// File: rtl/uirq_csr_file.sv
// Module: uirq_csr_file
// Holds the software pending bit, the machine-held timer/external
// pending copies and the three enable bits. Presents them through the
// four views and hands compressed pending/enable vectors to the
// arbiter. Assumes XLEN > 8 so that every source position exists.
module uirq_csr_file
    import uirq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tmr_line_i,
    input  logic            ext_line_i,
    input  logic [1:0]      csr_sel_i,
    input  logic            csr_we_i,
    input  logic [XLEN-1:0] csr_wdata_i,
    input  logic            priv_user_i,
    output logic [XLEN-1:0] csr_rdata_o,
    output logic [NSRC-1:0] pend_o,
    output logic [NSRC-1:0] en_o
);

    localparam logic [XLEN-1:0] IMPL_MASK =
        XLEN'((1 << src_pos(SRC_SW)) | (1 << src_pos(SRC_TMR)) |
              (1 << src_pos(SRC_EXT)));

    logic            is_pend_view;
    logic            is_en_view;
    logic            access_ok;
    logic            pend_wr;
    logic            en_wr;
    logic            sw_pend_q;
    logic            tmr_held_q;
    logic            ext_held_q;
    logic [NSRC-1:0] en_q;
    logic [XLEN-1:0] pend_word;
    logic [XLEN-1:0] en_word;
    logic [XLEN-1:0] unused_wdata;

    // Decode the selected view and whether the current mode may use it.
    always_comb begin
        is_pend_view = (csr_sel_i == VIEW_UPEND) || (csr_sel_i == VIEW_MPEND);
        is_en_view   = (csr_sel_i == VIEW_UEN)   || (csr_sel_i == VIEW_MEN);
        access_ok    = !(priv_user_i && csr_sel_i[1]);
        pend_wr      = csr_we_i && access_ok && is_pend_view;
        en_wr        = csr_we_i && access_ok && is_en_view;
    end

    assign unused_wdata = csr_wdata_i & ~IMPL_MASK;

    // Software pending bit: writable through any permitted pending view.
    always_ff @(posedge clk) begin
        if (!rst_n)       sw_pend_q <= 1'b0;
        else if (pend_wr) sw_pend_q <= csr_wdata_i[src_pos(SRC_SW)];
    end

    // Held timer/external pending copies: machine-mode writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_held_q <= 1'b0;
            ext_held_q <= 1'b0;
        end else if (pend_wr && !priv_user_i) begin
            tmr_held_q <= csr_wdata_i[src_pos(SRC_TMR)];
            ext_held_q <= csr_wdata_i[src_pos(SRC_EXT)];
        end
    end

    // One enable flop per source, loaded from its own bit position.
    for (genvar i = 0; i < NSRC; i++) begin : gen_en
        always_ff @(posedge clk) begin
            if (!rst_n)     en_q[i] <= 1'b0;
            else if (en_wr) en_q[i] <= csr_wdata_i[src_pos(i)];
        end
    end

    // Compressed per-source pending, platform lines ORed in.
    always_comb begin
        pend_o[SRC_SW]  = sw_pend_q;
        pend_o[SRC_TMR] = tmr_held_q | tmr_line_i;
        pend_o[SRC_EXT] = ext_held_q | ext_line_i;
        en_o            = en_q;
    end

    // Expand compressed vectors to register words.
    always_comb begin
        pend_word = '0;
        en_word   = '0;
        for (int i = 0; i < NSRC; i++) begin
            pend_word[src_pos(i)] = pend_o[i];
            en_word[src_pos(i)]   = en_q[i];
        end
    end

    // Read mux: blocked machine views read zero.
    always_comb begin
        if (!access_ok)        csr_rdata_o = '0;
        else if (is_pend_view) csr_rdata_o = pend_word;
        else                   csr_rdata_o = en_word;
    end

    assert_sw_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we_i && !csr_sel_i[0] && !(priv_user_i && csr_sel_i[1]))
        |=> (pend_o[SRC_SW] == $past(csr_wdata_i[0])));

    assert_user_held_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we_i && priv_user_i) |=> ($stable(tmr_held_q) && $stable(ext_held_q)));

    assert_mview_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we_i && priv_user_i && csr_sel_i[1])
        |=> ($stable(en_q) && $stable(sw_pend_q)));

    assert_unimpl_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((csr_rdata_o & ~IMPL_MASK) == '0));

endmodule

// File: rtl/uirq_arbiter.sv
// Module: uirq_arbiter
// Qualifies each source with enable, delegation, global enable and
// user mode, then picks one by fixed priority (external, software,
// timer). Purely combinational; clk/rst_n feed the assertions only.
module uirq_arbiter
    import uirq_pkg::*;
#(
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    pend_i,
    input  logic [NSRC-1:0]    en_i,
    input  logic [NSRC-1:0]    deleg_i,
    input  logic               uie_i,
    input  logic               priv_user_i,
    output logic               irq_req_o,
    output logic [CAUSE_W-1:0] irq_code_o
);

    logic [NSRC-1:0] ready;

    // A source is ready when every gating term is true.
    always_comb begin
        ready = pend_i & en_i & deleg_i & {NSRC{uie_i && priv_user_i}};
    end

    // Fixed priority: walk from lowest to highest rank, last hit wins.
    always_comb begin
        irq_req_o  = 1'b0;
        irq_code_o = '0;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (ready[prio_src(k)]) begin
                irq_req_o  = 1'b1;
                irq_code_o = CAUSE_W'(src_pos(prio_src(k)));
            end
        end
    end

    assert_req_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (uie_i && priv_user_i && |(pend_i & en_i & deleg_i)));

    assert_ext_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i[SRC_EXT] && en_i[SRC_EXT] && deleg_i[SRC_EXT] && uie_i && priv_user_i)
        |-> (irq_code_o == CAUSE_W'(src_pos(SRC_EXT))));

    assert_idle_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req_o |-> (irq_code_o == '0));

endmodule

// File: rtl/uirq_ctrl.sv
// Module: uirq_ctrl (top)
// User interrupt pending/enable views over machine-level storage plus
// the request arbiter. Assumes XLEN > 8 and CAUSE_W >= 4.
module uirq_ctrl
    import uirq_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tmr_line_i,
    input  logic               ext_line_i,
    input  logic [1:0]         csr_sel_i,
    input  logic               csr_we_i,
    input  logic [XLEN-1:0]    csr_wdata_i,
    output logic [XLEN-1:0]    csr_rdata_o,
    input  logic               priv_user_i,
    input  logic               uie_i,
    input  logic [XLEN-1:0]    deleg_i,
    output logic               irq_req_o,
    output logic [CAUSE_W-1:0] irq_code_o
);

    logic [NSRC-1:0] pend_bits;
    logic [NSRC-1:0] en_bits;
    logic [NSRC-1:0] deleg_bits;
    logic [XLEN-1:0] unused_deleg;

    // Pick the delegation bits at the source positions.
    for (genvar i = 0; i < NSRC; i++) begin : gen_deleg
        assign deleg_bits[i] = deleg_i[src_pos(i)];
    end
    assign unused_deleg = deleg_i;

    uirq_csr_file #(.XLEN(XLEN)) u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .tmr_line_i  (tmr_line_i),
        .ext_line_i  (ext_line_i),
        .csr_sel_i   (csr_sel_i),
        .csr_we_i    (csr_we_i),
        .csr_wdata_i (csr_wdata_i),
        .priv_user_i (priv_user_i),
        .csr_rdata_o (csr_rdata_o),
        .pend_o      (pend_bits),
        .en_o        (en_bits)
    );

    uirq_arbiter #(.CAUSE_W(CAUSE_W)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_i      (pend_bits),
        .en_i        (en_bits),
        .deleg_i     (deleg_bits),
        .uie_i       (uie_i),
        .priv_user_i (priv_user_i),
        .irq_req_o   (irq_req_o),
        .irq_code_o  (irq_code_o)
    );

endmodule

// File: tb/uirq_ctrl_bench.sv
module uirq_ctrl_bench;

    localparam int XLEN = 32;
    localparam int CW   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tmr_line = 1'b0, ext_line = 1'b0;
    logic [1:0]      sel = 2'd0;
    logic            we = 1'b0;
    logic [XLEN-1:0] wdata = '0;
    logic [XLEN-1:0] rdata;
    logic            priv_user = 1'b0, uie = 1'b0;
    logic [XLEN-1:0] deleg = '0;
    logic            req;
    logic [CW-1:0]   code;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    uirq_ctrl #(.XLEN(XLEN), .CAUSE_W(CW)) u_uirq_ctrl (
        .clk(clk), .rst_n(rst_n), .tmr_line_i(tmr_line), .ext_line_i(ext_line),
        .csr_sel_i(sel), .csr_we_i(we), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
        .priv_user_i(priv_user), .uie_i(uie), .deleg_i(deleg),
        .irq_req_o(req), .irq_code_o(code)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Write one view, returning at the falling edge after the update.
    task automatic wr(input logic [1:0] v, input logic [31:0] d, input logic user);
        @(negedge clk);
        sel = v; wdata = d; priv_user = user; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] v, input logic user, output logic [31:0] d);
        sel = v; priv_user = user; #1; d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int v = 0; v < 4; v++) begin
            rd(v[1:0], 1'b0, d);
            check("R1 view after reset", d, 32'h0);
        end
        check("R1 request after reset", {31'b0, req}, 32'h0);
    endtask

    task automatic t_sw_pending();
        logic [31:0] d;
        wr(2'd0, 32'h1, 1'b1);
        rd(2'd0, 1'b1, d); check("R2 user view sw set", d, 32'h1);
        rd(2'd2, 1'b0, d); check("R2 machine view sw set", d, 32'h1);
        wr(2'd2, 32'h0, 1'b0);
        rd(2'd0, 1'b1, d); check("R2 sw cleared", d, 32'h0);
    endtask

    task automatic t_user_ro();
        logic [31:0] d;
        wr(2'd0, 32'h111, 1'b1);
        rd(2'd0, 1'b0, d); check("R3 user write only bit0", d, 32'h001);
        wr(2'd0, 32'h110, 1'b0);
        rd(2'd0, 1'b0, d); check("R3 machine write held bits", d, 32'h110);
        wr(2'd2, 32'h0, 1'b0);
        tmr_line = 1'b1;
        rd(2'd0, 1'b1, d); check("R3 timer line visible", d, 32'h010);
        tmr_line = 1'b0; ext_line = 1'b1;
        rd(2'd2, 1'b0, d); check("R3 ext line visible", d, 32'h100);
        ext_line = 1'b0;
    endtask

    task automatic t_enable_alias();
        logic [31:0] d;
        wr(2'd1, 32'h111, 1'b1);
        rd(2'd3, 1'b0, d); check("R4 user enable seen by machine", d, 32'h111);
        wr(2'd3, 32'h100, 1'b0);
        rd(2'd1, 1'b1, d); check("R4 machine enable seen by user", d, 32'h100);
    endtask

    task automatic t_mview_locked();
        logic [31:0] d;
        wr(2'd3, 32'h011, 1'b1);
        rd(2'd3, 1'b0, d); check("R5 user write machine enable ignored", d, 32'h100);
        rd(2'd3, 1'b1, d); check("R5 user read machine view zero", d, 32'h0);
        wr(2'd2, 32'h001, 1'b1);
        rd(2'd2, 1'b0, d); check("R5 user write machine pending ignored", d, 32'h0);
    endtask

    task automatic t_unimpl();
        logic [31:0] d;
        wr(2'd1, 32'hFFFF_FFFF, 1'b0);
        rd(2'd1, 1'b0, d); check("R6 enable unimpl bits zero", d, 32'h111);
        wr(2'd2, 32'hFFFF_FFFF, 1'b0);
        rd(2'd2, 1'b0, d); check("R6 pending unimpl bits zero", d, 32'h111);
        wr(2'd2, 32'h0, 1'b0);
    endtask

    task automatic t_qualify();
        wr(2'd1, 32'h111, 1'b0);
        wr(2'd0, 32'h001, 1'b0);
        deleg = '1; uie = 1'b1; priv_user = 1'b1; #1;
        check("R7 all terms set req", {31'b0, req}, 32'h1);
        check("R7 sw code", {28'b0, code}, 32'h0);
        uie = 1'b0; #1;
        check("R7 uie off", {31'b0, req}, 32'h0);
        uie = 1'b1; priv_user = 1'b0; #1;
        check("R7 machine mode", {31'b0, req}, 32'h0);
        priv_user = 1'b1; deleg = 32'hFFFF_FFFE; #1;
        check("R7 not delegated", {31'b0, req}, 32'h0);
        deleg = '1;
        wr(2'd1, 32'h110, 1'b0);
        priv_user = 1'b1; #1;
        check("R7 enable off", {31'b0, req}, 32'h0);
        wr(2'd1, 32'h111, 1'b0);
    endtask

    task automatic t_priority();
        tmr_line = 1'b1; ext_line = 1'b1; priv_user = 1'b1; uie = 1'b1; #1;
        check("R8 all ready ext wins", {28'b0, code}, 32'h8);
        ext_line = 1'b0; #1;
        check("R8 sw over timer", {28'b0, code}, 32'h0);
        check("R8 sw request", {31'b0, req}, 32'h1);
        wr(2'd0, 32'h0, 1'b1);
        priv_user = 1'b1; #1;
        check("R8 timer alone", {28'b0, code}, 32'h4);
        ext_line = 1'b1; deleg = 32'hFFFF_FEFF; #1;
        check("R8 undelegated ext loses", {28'b0, code}, 32'h4);
        tmr_line = 1'b0; ext_line = 1'b0; deleg = '1;
    endtask

    task automatic t_idle();
        ext_line = 1'b1; uie = 1'b0; #1;
        check("R9 no request", {31'b0, req}, 32'h0);
        check("R9 idle code zero", {28'b0, code}, 32'h0);
        ext_line = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sw_pending();
        t_user_ro();
        t_enable_alias();
        t_mview_locked();
        t_unimpl();
        t_qualify();
        t_priority();
        t_idle();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule